// File: doc/BRIEF.md
# Host interrupt status controller

This block gathers up to sixteen single-cycle event pulses from device logic into sticky status bits and raises one interrupt line toward a host processor. The host reaches it through a small register bus (address, write strobe, read strobe, write data, read data). Through that bus the host can load the whole mask at once, or set and clear chosen mask bits without a read-modify-write. It can read status in two ways: one leaves status untouched, the other empties it. A separate acknowledge port retires chosen status bits.

Status bits latch whether or not they are masked; the mask only gates the interrupt line. The line is the OR of the unmasked pending bits, passed through one register, then through an enable and a polarity selection that come in as plain configuration pins. The bus carries only control and status, so it has no valid/ready handshake: a write takes effect at the clock edge that samples it, and read data is registered and appears one cycle after the read strobe.

Suggested bit use: 0 receive buffer 0, 1 transmit data, 2 transmit transfer, 3 receive buffer 1, 4 receive transfer, 5 and 6 event mailboxes, 7 wake, 8 and 9 trace, 10 command done, 14 init done. The logic treats all sixteen bits alike.

Top module: `host_irq_ctrl`

## Requirements
- R1: A mask bit at 1 keeps its status bit from driving the interrupt line; with every pending bit masked the line stays at its inactive level.
- R2: A write to address 1 (mask set) sets each mask bit written as 1 and leaves the other mask bits unchanged.
- R3: A write to address 2 (mask clear) clears each mask bit written as 1 and leaves the other mask bits unchanged.
- R4: A read of address 3 (status peek) returns the status bits and leaves them unchanged.
- R5: A read of address 4 (status take) returns the status bits and clears all of them at the same edge.
- R6: A write to address 5 (acknowledge) clears each status bit written as 1; bits written as 0 are unaffected.
- R7: After reset the mask is 0x0001 and the status is 0.
- R8: A pulse on a source input sets its status bit, which stays set until it is acknowledged or taken, whether masked or not.
- R9: With the enable pin low the line rests at its inactive level (high when active-low polarity is selected, low otherwise); with it high an active line is high for active-high polarity and low for active-low.
- R10: A source pulse in the same cycle as a take read or an acknowledge of its bit leaves that bit set.
- R11: The line changes two clock edges after a source pulse is presented: the edge that latches status, then the edge that registers the unmasked OR.
- R12: A write to address 0 loads the whole mask and a read of address 0 returns it; a read of any address other than 0, 3 or 4 returns 0; read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | SRC_W | Write data |
| rdata | output | SRC_W | Read data, registered, valid the cycle after rd_en |
| src_pulse | input | SRC_W | Event pulses from device logic, one bit per source |
| irq_en | input | 1 | Interrupt line enable |
| irq_active_low | input | 1 | Selects active-low polarity of the line |
| irq_o | output | 1 | Host interrupt line |

## Verification
The hardest case to reach is a new event landing in exactly the cycle in which the host takes or acknowledges that same bit. The other bus operations never show it, so the bench drives the source pulse and the bus strobe from one task at the same falling edge. It then peeks status to confirm the bit survived while the take read itself returned the older contents. The two-edge latency of the line is checked by sampling it once before and once after the registering edge.

// File: rtl/hirq_pkg.sv
`timescale 1ns/1ps
package hirq_pkg;
  localparam int SRC_W_DEF  = 16;
  localparam int ADDR_W_DEF = 3;
  localparam logic [SRC_W_DEF-1:0] MASK_RST_DEF = 16'h0001;

  typedef enum logic [ADDR_W_DEF-1:0] {
    A_MASK  = 3'd0,
    A_MSET  = 3'd1,
    A_MCLR  = 3'd2,
    A_PEEK  = 3'd3,
    A_TAKE  = 3'd4,
    A_ACK   = 3'd5
  } hirq_addr_e;

  localparam int EV_RXB0   = 0;
  localparam int EV_TXDATA = 1;
  localparam int EV_TXXFER = 2;
  localparam int EV_RXB1   = 3;
  localparam int EV_RXXFER = 4;
  localparam int EV_MBOX_A = 5;
  localparam int EV_MBOX_B = 6;
  localparam int EV_WAKE   = 7;
  localparam int EV_TRC_A  = 8;
  localparam int EV_TRC_B  = 9;
  localparam int EV_CMDDN  = 10;
  localparam int EV_INITDN = 14;
endpackage

// File: rtl/hirq_mask_reg.sv
`timescale 1ns/1ps
module hirq_mask_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         set,
  input  logic         clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask_q <= RST_VAL;
    else if (ld)  mask_q <= wdata;
    else if (set) mask_q <= mask_q | wdata;
    else if (clr) mask_q <= mask_q & ~wdata;
  end
endmodule

// File: rtl/hirq_status_bank.sv
`timescale 1ns/1ps
module hirq_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] ack_bits,
  input  logic         clr_all,
  output logic [W-1:0] stat_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     stat_q[i] <= 1'b0;
      else if (src[i])                stat_q[i] <= 1'b1;
      else if (clr_all || ack_bits[i]) stat_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hirq_out_stage.sv
`timescale 1ns/1ps
module hirq_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] mask,
  input  logic         irq_en,
  input  logic         irq_active_low,
  output logic         irq_o
);
  logic pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= 1'b0;
    else        pending_q <= |(stat & ~mask);
  end

  always_comb begin
    if (irq_en) irq_o = pending_q ^ irq_active_low;
    else        irq_o = irq_active_low;
  end
endmodule

// File: rtl/host_irq_ctrl.sv
`timescale 1ns/1ps
module host_irq_ctrl #(
  parameter int SRC_W  = hirq_pkg::SRC_W_DEF,
  parameter int ADDR_W = hirq_pkg::ADDR_W_DEF,
  parameter logic [SRC_W-1:0] MASK_RST = SRC_W'(hirq_pkg::MASK_RST_DEF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SRC_W-1:0]  wdata,
  output logic [SRC_W-1:0]  rdata,
  input  logic [SRC_W-1:0]  src_pulse,
  input  logic              irq_en,
  input  logic              irq_active_low,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(hirq_pkg::A_MASK);
  localparam logic [ADDR_W-1:0] AD_MSET = ADDR_W'(hirq_pkg::A_MSET);
  localparam logic [ADDR_W-1:0] AD_MCLR = ADDR_W'(hirq_pkg::A_MCLR);
  localparam logic [ADDR_W-1:0] AD_PEEK = ADDR_W'(hirq_pkg::A_PEEK);
  localparam logic [ADDR_W-1:0] AD_TAKE = ADDR_W'(hirq_pkg::A_TAKE);
  localparam logic [ADDR_W-1:0] AD_ACK  = ADDR_W'(hirq_pkg::A_ACK);

  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] stat_q;
  logic [SRC_W-1:0] ack_bits;
  logic [SRC_W-1:0] rd_mux;
  logic             wr_ld, wr_set, wr_clr, take_rd;

  assign wr_ld    = wr_en && (addr == AD_MASK);
  assign wr_set   = wr_en && (addr == AD_MSET);
  assign wr_clr   = wr_en && (addr == AD_MCLR);
  assign take_rd  = rd_en && (addr == AD_TAKE);
  assign ack_bits = (wr_en && (addr == AD_ACK)) ? wdata : '0;

  hirq_mask_reg #(.W(SRC_W), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .ld(wr_ld), .set(wr_set), .clr(wr_clr),
    .wdata(wdata), .mask_q(mask_q)
  );

  hirq_status_bank #(.W(SRC_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .src(src_pulse), .ack_bits(ack_bits),
    .clr_all(take_rd), .stat_q(stat_q)
  );

  hirq_out_stage #(.W(SRC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .stat(stat_q), .mask(mask_q),
    .irq_en(irq_en), .irq_active_low(irq_active_low), .irq_o(irq_o)
  );

  always_comb begin
    if (addr == AD_MASK)                         rd_mux = mask_q;
    else if (addr == AD_PEEK || addr == AD_TAKE) rd_mux = stat_q;
    else                                         rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/hirq_checker.sv
`timescale 1ns/1ps
module hirq_checker #(
  parameter int SRC_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [SRC_W-1:0]  wdata,
  input logic [SRC_W-1:0]  src,
  input logic [SRC_W-1:0]  stat,
  input logic [SRC_W-1:0]  mask,
  input logic              irq_en,
  input logic              irq_active_low,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] K_MSET = ADDR_W'(hirq_pkg::A_MSET);
  localparam logic [ADDR_W-1:0] K_MCLR = ADDR_W'(hirq_pkg::A_MCLR);
  localparam logic [ADDR_W-1:0] K_PEEK = ADDR_W'(hirq_pkg::A_PEEK);
  localparam logic [ADDR_W-1:0] K_TAKE = ADDR_W'(hirq_pkg::A_TAKE);
  localparam logic [ADDR_W-1:0] K_ACK  = ADDR_W'(hirq_pkg::A_ACK);

  p_quiet_when_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~mask) == '0) |=> (!irq_en || irq_o == irq_active_low));

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == K_MSET) |=> ((mask & $past(wdata)) == $past(wdata)));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == K_MCLR) |=> ((mask & $past(wdata)) == '0));

  p_peek_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == K_PEEK && src == '0) |=> (stat == $past(stat)));

  p_take_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == K_TAKE && src == '0) |=> (stat == '0));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == K_ACK && (wdata & src) == '0) |=> ((stat & $past(wdata)) == '0));

  p_event_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0) |=> ((stat & $past(src)) == $past(src)));

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> (irq_o == irq_active_low));
endmodule

bind host_irq_ctrl hirq_checker #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_hirq_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .src(src_pulse), .stat(stat_q), .mask(mask_q),
  .irq_en(irq_en), .irq_active_low(irq_active_low), .irq_o(irq_o)
);

// File: tb/tb_host_irq_ctrl.sv
`timescale 1ns/1ps
module tb_host_irq_ctrl;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wdata = '0, src_pulse = '0;
  logic         irq_en = 1'b1, irq_active_low = 1'b0;
  logic [W-1:0] rdata;
  logic         irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] m_mask, m_stat;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         mon_arm = 1'b0;

  always #4 clk = ~clk;

  host_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .src_pulse(src_pulse), .irq_en(irq_en),
    .irq_active_low(irq_active_low), .irq_o(irq_o)
  );

  // monitor: read data is valid at the falling edge after the sampling edge
  always @(posedge clk) mon_arm <= rd_en;
  always @(negedge clk) begin
    if (mon_arm && exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: m_mask = d;
      3'd1: m_mask = m_mask | d;
      3'd2: m_mask = m_mask & ~d;
      3'd5: m_stat = m_stat & ~d;
      default: ;
    endcase
  endtask

  task automatic bus_rd(input logic [2:0] a, input string t);
    logic [W-1:0] e;
    case (a)
      3'd0: e = m_mask;
      3'd3, 3'd4: e = m_stat;
      default: e = '0;
    endcase
    exp_q.push_back(e); tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (a == 3'd4) m_stat = '0;
  endtask

  task automatic pulse(input logic [W-1:0] b);
    src_pulse = b;
    @(negedge clk);
    src_pulse = '0;
    m_stat = m_stat | b;
  endtask

  task automatic take_race(input logic [W-1:0] b);
    exp_q.push_back(m_stat); tag_q.push_back("R10 take-race read");
    addr = 3'd4; rd_en = 1'b1; src_pulse = b;
    @(negedge clk);
    rd_en = 1'b0; src_pulse = '0;
    m_stat = b;
  endtask

  task automatic ack_race(input logic [W-1:0] b);
    addr = 3'd5; wdata = b; wr_en = 1'b1; src_pulse = b;
    @(negedge clk);
    wr_en = 1'b0; src_pulse = '0;
    m_stat = m_stat | b;
  endtask

  task automatic chk_irq(input logic e, input string t);
    #1;
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq_o actual %b expected %b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_mask = 16'h0001; m_stat = '0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R7 reset state
    chk_irq(1'b0, "R7 line after reset");
    bus_rd(3'd0, "R7 mask reset");
    bus_rd(3'd3, "R7 status reset");
    // R8 masked event still latches, R1 masked bit keeps line quiet
    pulse(16'h0001);
    idle(2);
    chk_irq(1'b0, "R1 masked source");
    bus_rd(3'd3, "R8 masked bit sticky");
    // R3 clearing mask bit exposes the pending bit
    bus_wr(3'd2, 16'h0001);
    idle(2);
    chk_irq(1'b1, "R3 unmask raises line");
    bus_rd(3'd0, "R3 mask after clear");
    // R5 take read
    bus_rd(3'd4, "R5 take returns status");
    bus_rd(3'd3, "R5 status empty after take");
    idle(1);
    chk_irq(1'b0, "R5 line drops after take");
    // R11 latency
    pulse(16'h0008);
    chk_irq(1'b0, "R11 line before register edge");
    idle(1);
    chk_irq(1'b1, "R11 line after register edge");
    bus_rd(3'd4, "R11 take");
    // R12 direct load and unmapped read
    bus_wr(3'd0, 16'hF0F0);
    bus_rd(3'd0, "R12 mask load");
    bus_rd(3'd6, "R12 unmapped address");
    bus_rd(3'd1, "R12 write-only address");
    // R2, R3 atomic mask updates
    bus_wr(3'd1, 16'h0101);
    bus_rd(3'd0, "R2 mask set");
    bus_wr(3'd2, 16'h1010);
    bus_rd(3'd0, "R3 mask clear");
    // R4 peek twice
    pulse(16'h4402);
    bus_rd(3'd3, "R4 first peek");
    bus_rd(3'd3, "R4 second peek");
    // R6 acknowledge
    bus_wr(3'd5, 16'h0400);
    bus_rd(3'd3, "R6 ack one bit");
    bus_wr(3'd5, 16'h0000);
    bus_rd(3'd3, "R6 ack zero no effect");
    // R10 races
    take_race(16'h0020);
    bus_rd(3'd3, "R10 event survives take");
    ack_race(16'h0020);
    bus_rd(3'd3, "R10 event survives ack");
    // R9 enable and polarity
    bus_wr(3'd0, 16'h0000);
    idle(2);
    chk_irq(1'b1, "R9 active high asserted");
    irq_active_low = 1'b1;
    chk_irq(1'b0, "R9 active low asserted");
    irq_en = 1'b0;
    chk_irq(1'b1, "R9 disabled active low idles high");
    irq_active_low = 1'b0;
    chk_irq(1'b0, "R9 disabled active high idles low");
    irq_en = 1'b1;
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule